// File: doc/BRIEF.md
# Power-Budgeted Self-Test Session Sequencer

This block steps through a fixed schedule of self-test sessions. A session is a group of tests that run side by side. Each test drives one core under test through its own pseudo-random pattern generator. The core's responses are folded into a per-test signature register. The schedule is set by parameters: a clock length and a power weight per test, a membership mask per session, and one power ceiling. At the start of a session the sequencer adds up the weights of the member tests. A session whose total exceeds the ceiling is skipped and flagged. A session that fits runs for as many clocks as its longest member. A member that is shorter than its session stops stepping its generator and its signature register when its own length runs out.

A pulse on the start input launches the schedule. When the last session ends, the block raises done for one clock. In that same clock, pass shows whether every signature equals the expected value supplied at the expected-signature input and no session was skipped. A start that arrives while the schedule is running has no effect. The block has no data streams: every pin is a plain control or status level, so no back-pressure rules apply.

Top module: `bist_session_ctrl`

## Requirements
- R1: Out of reset the block is idle. busy, done, pass, err and all test enables are 0, and every signature reads the seed value 0xFF.
- R2: Sessions run in schedule order. With the default schedule they are {T3,T4}, then {T2,T5}, then {T1,T6}, where test Tk is bit k-1 of every per-test vector. The test enable of every member is high for the whole session, and only in that session.
- R3: A session lasts as many clocks as its longest member. Each session costs one setup clock before its run clocks. With the default schedule the member tests first step 2, 13 and 24 clocks after the start pulse is sampled.
- R4: A member test's generator and signature enables are high only for the first length-of-test clocks of its session. After that its signature holds: T4 steps for 5 clocks and the others for 10 or 100.
- R5: The summed power weight of the enabled tests never exceeds the ceiling (default 4). A session over the ceiling runs none of its tests and sets err, which stays set until the next accepted start.
- R6: Each generator is seeded to 0x01 at session setup and shows its state on its stim lane. In each enabled clock it steps as next = (s >> 1) XOR (s[0] ? 0xB8 : 0), and its state is never zero.
- R7: Each signature register is seeded to 0xFF at session setup. In each enabled clock it takes next = ((m >> 1) XOR (m[0] ? 0xB8 : 0)) XOR resp, where resp is the response lane of the same test.
- R8: In the done clock, pass is 1 only if err is 0 and every signature equals its expected lane. At all other times pass is 0.
- R9: A start pulse while busy is ignored. The schedule, its timing and its result are unchanged.
- R10: done is high for exactly one clock, NUM_SESS + total run clocks + 1 clocks after start is sampled (124 with the default schedule). busy is high from setup until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch the schedule; ignored while busy |
| test_en_o | output | NUM_TESTS | Test is a member of the running session |
| lfsr_en_o | output | NUM_TESTS | Pattern generator of the test steps this clock |
| misr_en_o | output | NUM_TESTS | Signature register of the test absorbs this clock |
| stim_o | output | NUM_TESTS*SIG_W | Pattern lanes to the cores, lane k for test k+1 |
| resp_i | input | NUM_TESTS*SIG_W | Response lanes from the cores |
| exp_sig_i | input | NUM_TESTS*SIG_W | Expected final signatures |
| sig_o | output | NUM_TESTS*SIG_W | Current signatures |
| busy_o | output | 1 | Schedule in progress |
| done_o | output | 1 | One-clock end-of-schedule pulse |
| pass_o | output | 1 | All signatures matched, valid with done |
| err_o | output | 1 | A session exceeded the power ceiling |

## Verification
The assertions assume that every scheduled test has a nonzero length that fits the run counter, that no session is empty, and that each response lane settles within the clock that its pattern lane is presented. The bench models each core as a fixed combinational function of its own pattern lane, so responses settle in the same clock and depend on nothing else. It keeps the schedule parameters to legal lengths, with one extra instance whose middle session is deliberately over the ceiling. It raises start only from idle, except for one pulse that is placed in the middle of a run to test R9.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_i,
  input  logic         en_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= SEED;
    else if (seed_i) st_q <= SEED;
    else if (en_i)   st_q <= (st_q >> 1) ^ (st_q[0] ? POLY : '0);
  end

  assign q_o = st_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0); // R6
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'hB8,
  parameter logic [W-1:0] SEED = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig_q <= SEED;
    else if (seed_i) sig_q <= SEED;
    else if (en_i)   sig_q <= ((sig_q >> 1) ^ (sig_q[0] ? POLY : '0)) ^ d_i;
  end

  assign q_o = sig_q;

  AST_MISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !seed_i) |=> $stable(sig_q)); // R4
endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import bist_pkg::*;
#(
  parameter int unsigned NUM_TESTS = 6,
  parameter int unsigned NUM_SESS  = 3,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PWR_MAX   = 4,
  parameter int unsigned TEST_LEN [NUM_TESTS] = '{100, 10, 10, 5, 10, 100},
  parameter int unsigned TEST_PWR [NUM_TESTS] = '{2, 1, 1, 1, 2, 1},
  parameter logic [NUM_TESTS-1:0] SESS_MASK [NUM_SESS] = '{6'b001100, 6'b010010, 6'b100001}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic [NUM_TESTS-1:0] test_en_o,
  output logic [NUM_TESTS-1:0] act_o,
  output logic [NUM_TESTS-1:0] seed_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o
);
  localparam int unsigned SW = (NUM_SESS > 1) ? $clog2(NUM_SESS) : 1;
  localparam logic [SW-1:0] LAST = SW'(NUM_SESS - 1);

  seq_state_t           state_q;
  logic [SW-1:0]        sess_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 err_q;
  logic [NUM_TESTS-1:0] mask;
  int unsigned          pwr, slen;
  logic                 over, cnt_end;

  always_comb begin
    mask = SESS_MASK[sess_q];
    pwr  = 0;
    slen = 0;
    for (int i = 0; i < NUM_TESTS; i++) begin
      if (mask[i]) begin
        pwr = pwr + TEST_PWR[i];
        if (TEST_LEN[i] > slen) slen = TEST_LEN[i];
      end
    end
    over    = pwr > PWR_MAX;
    cnt_end = (32'(cnt_q) + 32'd1) >= slen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sess_q  <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SETUP;
          sess_q  <= '0;
          cnt_q   <= '0;
          err_q   <= 1'b0;
        end
        ST_SETUP: begin
          cnt_q <= '0;
          if (over) begin
            err_q <= 1'b1;
            if (sess_q == LAST) state_q <= ST_FIN;
            else                sess_q  <= sess_q + SW'(1);
          end else begin
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt_end) begin
            if (sess_q == LAST) state_q <= ST_FIN;
            else begin
              sess_q  <= sess_q + SW'(1);
              state_q <= ST_SETUP;
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_TESTS; i++) begin
      test_en_o[i] = (state_q == ST_RUN) && mask[i];
      act_o[i]     = (state_q == ST_RUN) && mask[i] && (32'(cnt_q) < TEST_LEN[i]);
      seed_o[i]    = (state_q == ST_SETUP) && !over && mask[i];
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign done_o = state_q == ST_FIN;
  assign err_o  = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_SKIP_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETUP && over) |=> state_q != ST_RUN); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !cnt_end) |=> (state_q == ST_RUN && $stable(sess_q))); // R9
endmodule

// File: rtl/bist_session_ctrl.sv
module bist_session_ctrl #(
  parameter int unsigned NUM_TESTS = 6,
  parameter int unsigned NUM_SESS  = 3,
  parameter int unsigned SIG_W     = 8,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned PWR_MAX   = 4,
  parameter logic [SIG_W-1:0] POLY      = 8'hB8,
  parameter logic [SIG_W-1:0] LFSR_SEED = 8'h01,
  parameter logic [SIG_W-1:0] MISR_SEED = 8'hFF,
  parameter int unsigned TEST_LEN [NUM_TESTS] = '{100, 10, 10, 5, 10, 100},
  parameter int unsigned TEST_PWR [NUM_TESTS] = '{2, 1, 1, 1, 2, 1},
  parameter logic [NUM_TESTS-1:0] SESS_MASK [NUM_SESS] = '{6'b001100, 6'b010010, 6'b100001}
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  output logic [NUM_TESTS-1:0]       test_en_o,
  output logic [NUM_TESTS-1:0]       lfsr_en_o,
  output logic [NUM_TESTS-1:0]       misr_en_o,
  output logic [NUM_TESTS*SIG_W-1:0] stim_o,
  input  logic [NUM_TESTS*SIG_W-1:0] resp_i,
  input  logic [NUM_TESTS*SIG_W-1:0] exp_sig_i,
  output logic [NUM_TESTS*SIG_W-1:0] sig_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       pass_o,
  output logic                       err_o
);
  logic [NUM_TESTS-1:0] act, seed, match;
  int unsigned          en_pwr;

  bist_seq #(
    .NUM_TESTS(NUM_TESTS), .NUM_SESS(NUM_SESS), .CNT_W(CNT_W), .PWR_MAX(PWR_MAX),
    .TEST_LEN(TEST_LEN), .TEST_PWR(TEST_PWR), .SESS_MASK(SESS_MASK)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .test_en_o(test_en_o), .act_o(act), .seed_o(seed),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  for (genvar g = 0; g < NUM_TESTS; g++) begin : g_lane
    bist_lfsr #(.W(SIG_W), .POLY(POLY), .SEED(LFSR_SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .seed_i(seed[g]), .en_i(act[g]),
      .q_o(stim_o[g*SIG_W +: SIG_W])
    );
    bist_misr #(.W(SIG_W), .POLY(POLY), .SEED(MISR_SEED)) u_misr (
      .clk(clk), .rst_n(rst_n), .seed_i(seed[g]), .en_i(act[g]),
      .d_i(resp_i[g*SIG_W +: SIG_W]), .q_o(sig_o[g*SIG_W +: SIG_W])
    );
    assign match[g] = sig_o[g*SIG_W +: SIG_W] == exp_sig_i[g*SIG_W +: SIG_W];
  end

  assign lfsr_en_o = act;
  assign misr_en_o = act;
  assign pass_o    = done_o && !err_o && (&match);

  always_comb begin
    en_pwr = 0;
    for (int i = 0; i < NUM_TESTS; i++)
      if (test_en_o[i]) en_pwr = en_pwr + TEST_PWR[i];
  end

  AST_POWER_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    en_pwr <= PWR_MAX); // R5
  AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (done_o && !err_o)); // R8
endmodule

// File: tb/tb_bist_session_ctrl.sv
`timescale 1ns/1ps
module tb_bist_session_ctrl;
  localparam int NT = 6;
  localparam int W  = 8;
  // per test: {length, first stepping clock after start}
  localparam int unsigned VEC [NT][2] = '{'{100, 24}, '{10, 13}, '{10, 2},
                                          '{5, 2}, '{10, 13}, '{100, 24}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [NT-1:0] te, le, me, o_te, o_le, o_me;
  logic [NT*W-1:0] stim, resp, expv, sig, o_stim, o_resp, o_sig;
  logic busy, done, pass, err, o_busy, o_done, o_pass, o_err;

  always #4 clk = ~clk;

  bist_session_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .test_en_o(te), .lfsr_en_o(le),
    .misr_en_o(me), .stim_o(stim), .resp_i(resp), .exp_sig_i(expv), .sig_o(sig),
    .busy_o(busy), .done_o(done), .pass_o(pass), .err_o(err));

  bist_session_ctrl #(.SESS_MASK('{6'b001100, 6'b010011, 6'b100001})) dut_ovr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .test_en_o(o_te), .lfsr_en_o(o_le),
    .misr_en_o(o_me), .stim_o(o_stim), .resp_i(o_resp), .exp_sig_i(expv), .sig_o(o_sig),
    .busy_o(o_busy), .done_o(o_done), .pass_o(o_pass), .err_o(o_err));

  for (genvar g = 0; g < NT; g++) begin : g_cut
    assign resp[g*W +: W]   = stim[g*W +: W] ^ 8'(8'h11 * (g + 1));
    assign o_resp[g*W +: W] = o_stim[g*W +: W] ^ 8'(8'h11 * (g + 1));
  end

  int checks = 0, errors = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] step(input logic [7:0] x);
    return (x >> 1) ^ (x[0] ? 8'hB8 : 8'h00);
  endfunction

  function automatic logic [7:0] msig(input int len, input int idx);
    logic [7:0] l = 8'h01, m = 8'hFF;
    for (int k = 0; k < len; k++) begin
      m = step(m) ^ (l ^ 8'(8'h11 * (idx + 1)));
      l = step(l);
    end
    return m;
  endfunction

  int cnt_a[NT], first_a[NT];
  int done_n, done_c, o_done_n;
  logic [NT-1:0] te2, le2, te7, le7, o_te_or;
  logic pass_at, err_at, o_pass_at, o_err_at, o_err5, busy60;

  task automatic run(input int extra_start);
    for (int i = 0; i < NT; i++) begin cnt_a[i] = 0; first_a[i] = -1; end
    done_n = -1; done_c = 0; o_done_n = -1; o_te_or = '0;
    start = 1'b1;
    for (int n = 1; n <= 160; n++) begin
      @(negedge clk);
      if (n == 1) start = 1'b0;
      if (n == extra_start) start = 1'b1;
      if (n == extra_start + 1) start = 1'b0;
      for (int i = 0; i < NT; i++)
        if (le[i]) begin cnt_a[i]++; if (first_a[i] < 0) first_a[i] = n; end
      if (n == 2) begin te2 = te; le2 = le; end
      if (n == 7) begin te7 = te; le7 = le; end
      if (n == 5) o_err5 = o_err;
      if (n == 60) busy60 = busy;
      o_te_or = o_te_or | o_te;
      if (done) begin done_c++; done_n = n; pass_at = pass; err_at = err; end
      if (o_done) begin o_done_n = n; o_pass_at = o_pass; o_err_at = o_err; end
    end
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NT; i++) expv[i*W +: W] = msig(VEC[i][0], i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 err", err, 0);   check("R1 pass", pass, 0);
    check("R1 test_en", te, 0); check("R1 sig", sig, {NT{8'hFF}});

    run(-10);
    for (int i = 0; i < NT; i++) begin
      check($sformatf("R4 T%0d step count", i + 1), cnt_a[i], VEC[i][0]);
      check($sformatf("R3 T%0d first step", i + 1), first_a[i], VEC[i][1]);
      check($sformatf("R7 T%0d signature", i + 1), sig[i*W +: W], msig(VEC[i][0], i));
    end
    check("R2 session0 members", te2, 6'b001100);
    check("R2 session0 stepping", le2, 6'b001100);
    check("R4 T4 frozen, still enabled", te7, 6'b001100);
    check("R4 T4 frozen enables", le7, 6'b000100);
    check("R6 T4 pattern after 5 steps", stim[3*W +: W],
          step(step(step(step(step(8'h01))))));
    check("R10 busy mid-run", busy60, 1);
    check("R10 done time", done_n, 124);
    check("R10 done pulses", done_c, 1);
    check("R10 busy after", busy, 0);
    check("R8 pass on match", pass_at, 1);
    check("R8 pass outside done", pass, 0);
    check("R5 no err in budget", err_at, 0);
    check("R5 over-budget err", o_err_at, 1);
    check("R5 over-budget skip time", o_done_n, 114);
    check("R5 skipped tests never enabled", o_te_or & 6'b010010, 0);
    check("R5 skipped T5 sig", o_sig[4*W +: W], 8'hFF);
    check("R8 pass low on err", o_pass_at, 0);

    expv[3*W +: W] = ~expv[3*W +: W];
    run(50);
    check("R9 done time with busy start", done_n, 124);
    check("R9 single done", done_c, 1);
    check("R9 T1 count unchanged", cnt_a[0], 100);
    check("R8 pass low on mismatch", pass_at, 0);
    check("R5 err cleared by start", o_err5, 0);
    check("R5 err set again", o_err_at, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule